// File: doc/BRIEF.md
# ECP Parallel Port FIFO Controller

This block holds the extended control register, the data FIFO and the service-request logic of an ECP-capable parallel port, as seen from a byte-wide host register bus. The host picks an operating mode through a three-bit mode field. It sets the transfer direction in a control register. It moves bytes through a data port and watches the empty, full and service flags.

In test mode the host can both fill and drain the FIFO with no peripheral attached. This makes it possible to check data ordering and to measure the thresholds. A service request is latched when the fill level climbs to the read threshold (direction set) or when draining frees enough space to reach the write threshold (direction clear). The request can drive an interrupt line when it is unmasked. In configuration mode the fourth register reports the parallel word size. Only the 8-bit size exists.

The host bus is a plain strobe interface with no back-pressure. A write or read strobe is accepted in the cycle it is asserted. Read data is combinational from the address, and a data-port read pops at the following clock edge.

Top module: `ecp_fifo_ctrl`

## Requirements
- R1: After reset the mode register (address 2) reads 0x01: mode 000, interrupt mask bit 2 clear, empty flag bit 0 set. The status register (address 3) reads 0x00 and `svc_irq` is low.
- R2: The mode lives in bits 7:5 of address 2 (001 byte, 110 test, 111 configuration). Bits 4:2 read back as written. Writing 0x34 reads back 0x35 on an empty FIFO, and writing 0xd4 reads back 0xd5.
- R3: In test mode, bytes written to address 0 are read back from address 0 in the same order.
- R4: Bit 1 of address 2 is the full flag and bit 0 is the empty flag. Empty reads 1 in the cycle after the final byte is popped.
- R5: Outside test mode, writes and reads of address 0 leave the FIFO unchanged.
- R6: A write to a full FIFO is dropped, and the level never exceeds DEPTH (16).
- R7: A read from an empty FIFO returns the last byte popped and does not move the pointers.
- R8: With direction bit 5 of address 1 set, status bit 0 latches when a push brings the level to RD_THR (8).
- R9: With the direction bit clear, status bit 0 latches when a pop brings the free space to WR_THR (8).
- R10: Writing 1 to bit 0 of address 3 outside configuration mode clears the latched service request.
- R11: `svc_irq` equals the latched request while mask bit 2 of address 2 is 0, and is low while that bit is 1.
- R12: A write to address 2 that moves the mode out of test mode empties the FIFO.
- R13: In configuration mode address 3 reads 0x10, the word-size code 001 in bits 6:4 meaning 8-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 2 | Register select: 0 data, 1 control, 2 mode, 3 status/config |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe (pops on data port) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the addressed register |
| svc_irq | output | 1 | Unmasked service request |

## Verification
The FIFO is filled with an incrementing pattern in the reverse direction and drained in the forward direction. The first run shows ordering and the read threshold; the second shows the write threshold and that the two thresholds follow the direction bit. An extra byte pushed into a full FIFO and pops from an empty FIFO separate dropping from overwriting and underflow. A last-value readback followed by a fresh push and pop confirms the pointers did not move. Data-port traffic in byte mode and a test-to-byte mode change separate "ignored" from "flushed".

// File: rtl/ecp_fifo_pkg.sv
package ecp_fifo_pkg;
  typedef enum logic [2:0] {
    MODE_STD   = 3'b000,
    MODE_BYTE  = 3'b001,
    MODE_FCOMP = 3'b010,
    MODE_ECP   = 3'b011,
    MODE_EPP   = 3'b100,
    MODE_RSVD  = 3'b101,
    MODE_TEST  = 3'b110,
    MODE_CFG   = 3'b111
  } ecp_mode_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;
  localparam logic [1:0] ADDR_AUX  = 2'd3;

  localparam logic [2:0] WORD_8BIT = 3'b001;
endpackage

// File: rtl/ecp_fifo_mem.sv
module ecp_fifo_mem #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       store [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [7:0]       last_q;
  logic             do_push, do_pop;

  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        store[e] <= '0;
      else if (do_push && wr_ptr == PTR_W'(e))
        store[e] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= '0;
    else if (do_pop) last_q <= store[rd_ptr];
  end

  assign rdata = empty ? last_q : store[rd_ptr];
endmodule

// File: rtl/ecp_svc_logic.sv
module ecp_svc_logic #(
  parameter int DEPTH  = 16,
  parameter int RD_THR = 8,
  parameter int WR_THR = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             dir_rev,
  input  logic             clear,
  output logic             pending
);
  logic [LVL_W-1:0] space;
  logic             cond, cond_q;

  assign space = LVL_W'(DEPTH) - level;
  assign cond  = dir_rev ? (level >= LVL_W'(RD_THR)) : (space >= LVL_W'(WR_THR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q  <= 1'b1;
      pending <= 1'b0;
    end else begin
      cond_q <= cond;
      if (cond && !cond_q) pending <= 1'b1;
      else if (clear)      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/ecp_fifo_ctrl.sv
module ecp_fifo_ctrl
  import ecp_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int RD_THR = 8,
  parameter int WR_THR = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic       svc_irq
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  ecp_mode_e        mode_q;
  logic [1:0]       aux_q;
  logic             ecr_mask;
  logic [7:0]       ctrl_q;
  logic             in_test, in_cfg;
  logic             push_req, pop_req, leave_test, svc_clear, svc_pending;
  logic [7:0]       fifo_rdata;
  logic [LVL_W-1:0] fifo_level;
  logic             fifo_empty, fifo_full;

  assign in_test    = (mode_q == MODE_TEST);
  assign in_cfg     = (mode_q == MODE_CFG);
  assign push_req   = host_wr && host_addr == ADDR_DATA && in_test;
  assign pop_req    = host_rd && host_addr == ADDR_DATA && in_test;
  assign leave_test = host_wr && host_addr == ADDR_MODE && in_test &&
                      host_wdata[7:5] != MODE_TEST;
  assign svc_clear  = host_wr && host_addr == ADDR_AUX && !in_cfg && host_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_STD;
      aux_q    <= '0;
      ecr_mask <= 1'b0;
      ctrl_q   <= '0;
    end else if (host_wr) begin
      if (host_addr == ADDR_MODE) begin
        mode_q   <= ecp_mode_e'(host_wdata[7:5]);
        aux_q    <= host_wdata[4:3];
        ecr_mask <= host_wdata[2];
      end
      if (host_addr == ADDR_CTRL) ctrl_q <= host_wdata;
    end
  end

  ecp_fifo_mem #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_req),
    .pop   (pop_req),
    .flush (leave_test),
    .wdata (host_wdata),
    .rdata (fifo_rdata),
    .level (fifo_level),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  ecp_svc_logic #(.DEPTH(DEPTH), .RD_THR(RD_THR), .WR_THR(WR_THR), .LVL_W(LVL_W)) u_svc (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (fifo_level),
    .dir_rev (ctrl_q[5]),
    .clear   (svc_clear),
    .pending (svc_pending)
  );

  assign svc_irq = svc_pending && !ecr_mask;

  always_comb begin
    case (host_addr)
      ADDR_DATA: host_rdata = fifo_rdata;
      ADDR_CTRL: host_rdata = ctrl_q;
      ADDR_MODE: host_rdata = {mode_q, aux_q, ecr_mask, fifo_full, fifo_empty};
      default:   host_rdata = in_cfg ? {1'b0, WORD_8BIT, 4'b0000} : {7'b0, svc_pending};
    endcase
  end
endmodule

// File: rtl/ecp_fifo_ctrl_chk.sv
module ecp_fifo_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LVL_W-1:0] fifo_level,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic             push_req,
  input logic             pop_req,
  input logic             leave_test,
  input logic             svc_irq,
  input logic             ecr_mask
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LVL_W'(DEPTH));  // R6
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && fifo_full && !pop_req && !leave_test |=> fifo_full);  // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && fifo_empty && !push_req |=> fifo_empty);  // R7
  AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    leave_test |=> fifo_empty);  // R12
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ecr_mask |-> !svc_irq);  // R11
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));  // R4
endmodule

bind ecp_fifo_ctrl ecp_fifo_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fifo_level (fifo_level),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .push_req   (push_req),
  .pop_req    (pop_req),
  .leave_test (leave_test),
  .svc_irq    (svc_irq),
  .ecr_mask   (ecr_mask)
);

// File: tb/ecp_fifo_ctrl_bench.sv
module ecp_fifo_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = '0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       svc_irq;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ecp_fifo_ctrl u_ecp_fifo_ctrl (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .svc_irq(svc_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2, v); check("R1 mode reg", v, 8'h01);
    rd(3, v); check("R1 status", v, 8'h00);
    check("R1 irq", {7'b0, svc_irq}, 8'h00);
  endtask

  task automatic t_mode_and_fill;
    logic [7:0] v;
    wr(2, 8'h34); rd(2, v); check("R2 byte mode", v, 8'h35);
    wr(2, 8'hd4); rd(2, v); check("R2 test mode", v, 8'hd5);
    wr(1, 8'h20);
    for (int i = 0; i < 7; i++) wr(0, 8'hA0 + 8'(i));
    rd(3, v); check("R8 below read threshold", v, 8'h00);
    wr(0, 8'hA7);
    rd(3, v); check("R8 at read threshold", v, 8'h01);
    check("R11 masked irq", {7'b0, svc_irq}, 8'h00);
    wr(2, 8'hd0);
    check("R11 unmasked irq", {7'b0, svc_irq}, 8'h01);
    wr(3, 8'h01);
    rd(3, v); check("R10 cleared", v, 8'h00);
    check("R10 irq low", {7'b0, svc_irq}, 8'h00);
    for (int i = 8; i < 16; i++) wr(0, 8'hA0 + 8'(i));
    rd(2, v); check("R4 full flag", v, 8'hd2);
    wr(0, 8'hEE);
    rd(2, v); check("R6 still full", v, 8'hd2);
  endtask

  task automatic t_drain;
    logic [7:0] v;
    wr(1, 8'h00);
    for (int i = 0; i < 16; i++) begin
      rd(0, v); check("R3 order", v, 8'hA0 + 8'(i));
      if (i == 6) begin rd(3, v); check("R9 above write threshold", v, 8'h00); end
      if (i == 7) begin rd(3, v); check("R9 at write threshold", v, 8'h01); end
    end
    rd(2, v); check("R4 empty after last pop", v, 8'hd1);
    rd(0, v); check("R7 last value", v, 8'hAF);
    rd(0, v); check("R7 last value again", v, 8'hAF);
    wr(0, 8'h11);
    rd(0, v); check("R7 no underflow", v, 8'h11);
    rd(2, v); check("R7 empty again", v, 8'hd1);
  endtask

  task automatic t_flush_ignore;
    logic [7:0] v;
    wr(0, 8'h01); wr(0, 8'h02); wr(0, 8'h03);
    rd(2, v); check("R12 holds data", v, 8'hd0);
    wr(2, 8'h34);
    rd(2, v); check("R12 flushed", v, 8'h35);
    wr(0, 8'h55);
    rd(2, v); check("R5 byte-mode write", v, 8'h35);
    wr(2, 8'hd4);
    rd(2, v); check("R5 nothing queued", v, 8'hd5);
    wr(0, 8'h66); wr(2, 8'h34);
    wr(2, 8'h34);
    rd(0, v);
    wr(2, 8'hd4);
    rd(2, v); check("R5 read ignored", v, 8'hd5);
  endtask

  task automatic t_config;
    logic [7:0] v;
    wr(2, 8'hf4);
    rd(3, v); check("R13 word size", v, 8'h10);
    wr(2, 8'h14);
    rd(3, v); check("R13 status outside cfg", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode_and_fill();
    t_drain();
    t_flush_ignore();
    t_config();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule